// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects eight interrupt sources for a small stack processor and offers one request at a time, with the index of the source that should be serviced. Four sources come from external pins. These pins are sampled through a synchronizer, and each rising edge counts as one event. The other four come from on-chip logic as single-cycle event strobes. The highest of these, source 7, is wired to the periodic hardware timer.

Each source has a pending latch that records its event, and an enable bit in a mask register that software writes and reads back. A global enable flag sits above the whole mask and has separate set and clear strobes. A fixed-priority encoder picks the highest-numbered source that is both pending and enabled. The processor then services that source and writes its index back with an acknowledge, which clears only that pending latch. A pending latch holds its event while other sources are being serviced, so a burst of events is drained in priority order and none is dropped.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads 0x00, the global enable is off, no source is pending and `irq_req` is low.
- R2: A mask write takes effect at the next clock edge, and `mask_rdata` then returns exactly the value written. Bit n of the mask enables source n, so 0x80 enables only source 7.
- R3: When `irq_req` is high, `irq_idx` is the highest-numbered source that is pending and enabled. Source 7 has the highest priority and source 0 the lowest.
- R4: External source n (n = 0..3) is `ext_irq[n]` and passes through a two-flop synchronizer. A rising edge becomes pending at the third rising clock edge after the input goes high. An input held high does not trigger again, but each new rising edge does.
- R5: Internal source 4+k is `int_evt[k]`. A cycle in which it is high makes the source pending at the next clock edge.
- R6: A source becomes pending even while its mask bit is 0. It raises a request as soon as its mask bit is set.
- R7: While the global enable is off, `irq_req` stays low and pending sources are kept. Once the enable is set again they raise a request. `gie_set` turns the enable on, `gie_clr` turns it off, and when both are strobed together the clear wins.
- R8: When `irq_ack` is high, the pending bit of source `ack_idx` is cleared and no other pending bit changes. An acknowledge of a source that is not pending changes nothing.
- R9: If a source's event and its acknowledge fall in the same cycle, the source stays pending.
- R10: Events that arrive together on several sources are all kept, and they are serviced one at a time in order from the highest index down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_irq | input | 4 | External asynchronous request pins, sources 0..3 |
| int_evt | input | 4 | Internal event strobes, sources 4..7 (bit 3 is the timer) |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| mask_rdata | output | 8 | Mask register read data |
| gie_set | input | 1 | Global enable set strobe |
| gie_clr | input | 1 | Global enable clear strobe |
| irq_req | output | 1 | An enabled interrupt is pending |
| irq_idx | output | 3 | Index of the source to service |
| irq_ack | input | 1 | Acknowledge strobe |
| ack_idx | input | 3 | Index of the source being acknowledged |

## Verification
The assertions assume that the internal strobes and all CPU-side controls are synchronous to `clk`. They also assume that `ack_idx` is a valid index whenever `irq_ack` is high. The external pins are the only inputs allowed to change freely. The bench drives every input just after the falling clock edge, so each input is stable at the rising edge that samples it. Each external pulse is held high and then low for at least three clocks, so that every rising edge passes through the synchronizer as a separate event.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int IRQ_N    = 8;
    localparam int IRQ_IDXW = $clog2(IRQ_N);
    typedef logic [IRQ_N-1:0]    irq_vec_t;
    typedef logic [IRQ_IDXW-1:0] irq_idx_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], pin_i};
        s_d.last = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.sh[STAGES-1] & ~s_q.last;

    // R4: one level change gives a single event, never two in a row
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/irq_state.sv
module irq_state
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t evt_i,
    input  logic     ack_i,
    input  irq_idx_t ack_idx_i,
    input  logic     mask_we_i,
    input  irq_vec_t mask_wdata_i,
    input  logic     gie_set_i,
    input  logic     gie_clr_i,
    output irq_vec_t pend_o,
    output irq_vec_t mask_o,
    output logic     gie_o
);
    typedef struct packed {
        irq_vec_t pend;
        irq_vec_t mask;
        logic     gie;
    } st_t;

    st_t st_q, st_d;
    irq_vec_t clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = ack_i ? (irq_vec_t'(1) << ack_idx_i) : '0;
        st_d.pend = (st_q.pend & ~clr_d) | evt_i;
        if (mask_we_i) st_d.mask = mask_wdata_i;
        if (gie_clr_i)      st_d.gie = 1'b0;
        else if (gie_set_i) st_d.gie = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign gie_o  = st_q.gie;

    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_o == $past(mask_wdata_i)));

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr_i |=> !gie_o);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !evt_i[ack_idx_i]) |=> !pend_o[$past(ack_idx_i)]);

    for (genvar g = 0; g < IRQ_N; g++) begin : g_evt_chk
        // R9 and R6: an event always leaves the source pending
        a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> pend_o[g]);
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t active_i,
    output logic     any_o,
    output irq_idx_t idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < IRQ_N; i++) begin
            if (active_i[i]) begin
                any_o = 1'b1;
                idx_o = i[IRQ_IDXW-1:0];
            end
        end
    end

    a_r3_chosen_active: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> active_i[idx_o]);

    a_r3_none_higher: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ((active_i >> idx_o) == irq_vec_t'(1)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int N_EXT       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_EXT-1:0]      ext_irq,
    input  logic [IRQ_N-N_EXT-1:0] int_evt,
    input  logic                  mask_we,
    input  logic [IRQ_N-1:0]      mask_wdata,
    output logic [IRQ_N-1:0]      mask_rdata,
    input  logic                  gie_set,
    input  logic                  gie_clr,
    output logic                  irq_req,
    output logic [IRQ_IDXW-1:0]   irq_idx,
    input  logic                  irq_ack,
    input  logic [IRQ_IDXW-1:0]   ack_idx
);
    logic [N_EXT-1:0] ext_rise;
    irq_vec_t         evt, pend, mask, active;
    logic             gie;

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (ext_irq[g]),
            .rise_o (ext_rise[g])
        );
    end

    assign evt = {int_evt, ext_rise};

    irq_state u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt),
        .ack_i        (irq_ack),
        .ack_idx_i    (ack_idx),
        .mask_we_i    (mask_we),
        .mask_wdata_i (mask_wdata),
        .gie_set_i    (gie_set),
        .gie_clr_i    (gie_clr),
        .pend_o       (pend),
        .mask_o       (mask),
        .gie_o        (gie)
    );

    assign active = pend & mask & {IRQ_N{gie}};

    irq_prio_enc u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .any_o    (irq_req),
        .idx_o    (irq_idx)
    );

    assign mask_rdata = mask;

    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_req);

    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> mask[irq_idx]);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ext_irq = '0;
    logic [3:0] int_evt = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic [7:0] mask_rdata;
    logic       gie_set = 1'b0, gie_clr = 1'b0;
    logic       irq_req;
    logic [2:0] irq_idx;
    logic       irq_ack = 1'b0;
    logic [2:0] ack_idx = '0;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .int_evt(int_evt),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
        .gie_set(gie_set), .gie_clr(gie_clr), .irq_req(irq_req),
        .irq_idx(irq_idx), .irq_ack(irq_ack), .ack_idx(ack_idx)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // request present with given index (exp_idx < 0 means no request)
    task automatic chk_req(string req, int exp_idx);
        if (exp_idx < 0) chk(req, int'(irq_req), 0);
        else begin
            chk(req, int'(irq_req), 1);
            chk(req, int'(irq_idx), exp_idx);
        end
    endtask

    task automatic set_mask(logic [7:0] v);
        mask_we = 1'b1; mask_wdata = v;
        tick();
        mask_we = 1'b0;
    endtask

    task automatic strobe(logic [3:0] v);
        int_evt = v;
        tick();
        int_evt = '0;
    endtask

    task automatic ack(int idx);
        irq_ack = 1'b1; ack_idx = idx[2:0];
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic gie(bit s, bit c);
        gie_set = s; gie_clr = c;
        tick();
        gie_set = 1'b0; gie_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mask", int'(mask_rdata), 0);
        chk_req("R1 req", -1);
        set_mask(8'hFF);
        chk_req("R1 nothing pending", -1);
        gie(1, 0);
        chk_req("R1 nothing pending gie on", -1);
        gie(0, 1);
    endtask

    task automatic t_mask();
        set_mask(8'h80);
        chk("R2 readback 80", int'(mask_rdata), 8'h80);
        set_mask(8'h5A);
        chk("R2 readback 5A", int'(mask_rdata), 8'h5A);
        gie(1, 0);
        strobe(4'b1000);
        chk_req("R2 bit7 clear masks src7", -1);
        set_mask(8'h80);
        chk_req("R2 0x80 enables src7", 7);
        ack(7);
        chk_req("R2 cleared", -1);
    endtask

    task automatic t_gie();
        set_mask(8'hFF);
        gie(0, 1);
        strobe(4'b0010);
        chk_req("R7 off no req", -1);
        gie(1, 0);
        chk_req("R7 on raises kept pending", 5);
        gie(1, 1);
        chk_req("R7 clear wins", -1);
        gie(1, 0);
        chk_req("R7 still pending", 5);
        ack(5);
        chk_req("R7 cleared", -1);
    endtask

    task automatic t_masked();
        set_mask(8'h00);
        strobe(4'b0100);
        chk_req("R6 masked no req", -1);
        set_mask(8'h40);
        chk_req("R6 unmask raises", 6);
        ack(6);
        set_mask(8'hFF);
    endtask

    task automatic t_ext();
        ext_irq[2] = 1'b1;
        tick(); tick();
        chk_req("R4 not yet after 2 edges", -1);
        tick();
        chk_req("R4 pending after 3 edges", 2);
        ack(2);
        repeat (5) tick();
        chk_req("R4 held level no retrigger", -1);
        ext_irq[2] = 1'b0;
        repeat (3) tick();
        ext_irq[2] = 1'b1;
        repeat (3) tick();
        chk_req("R4 second edge", 2);
        ack(2);
        ext_irq[2] = 1'b0;
        repeat (3) tick();
    endtask

    task automatic t_int();
        int_evt = 4'b0001;
        tick();
        chk_req("R5 internal next edge", 4);
        int_evt = '0;
        ack(4);
        chk_req("R5 cleared", -1);
    endtask

    task automatic t_prio_ack();
        strobe(4'b1010);
        chk_req("R3 7 over 5", 7);
        ack(4);
        chk_req("R8 ack non-pending no change", 7);
        ack(7);
        chk_req("R8 only 7 cleared", 5);
        ack(5);
        chk_req("R8 all clear", -1);
    endtask

    task automatic t_same_cycle();
        strobe(4'b0100);
        int_evt = 4'b0100; irq_ack = 1'b1; ack_idx = 3'd6;
        tick();
        int_evt = '0; irq_ack = 1'b0;
        chk_req("R9 event beats ack", 6);
        ack(6);
        chk_req("R9 then cleared", -1);
    endtask

    task automatic t_burst();
        ext_irq = 4'hF;
        int_evt = 4'b1000;
        tick();
        int_evt = '0;
        tick(); tick();
        for (int k = 0; k < 5; k++) begin
            int exp = (k == 0) ? 7 : 4 - k;
            chk_req("R10 burst order", exp);
            ack(exp);
        end
        chk_req("R10 burst drained", -1);
        ext_irq = '0;
        repeat (3) tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_mask();
        t_gie();
        t_masked();
        t_ext();
        t_int();
        t_prio_ack();
        t_same_cycle();
        t_burst();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule